// File: doc/BRIEF.md
# DS3 Transmit Frame Timing Selector

This block paces the transmit side of a DS3 framer. It can take its bit timing from one of three places: the clock recovered by the receiver, a local transmit clock, or an external reference that marks M-frame boundaries. Everything runs in one fast system clock. Each source arrives as a one-cycle bit strobe, and the frame reference arrives as a raw asynchronous level. The block counts bit positions across a 4760-bit M-frame. It tells the payload logic when a bit is taken (`bit_en`) and when a frame begins (`frame_start`).

The line side is single-rail. The positive rail carries the serial frame content. The negative rail goes high only during the first bit of each frame, so it serves as a frame marker.

A change of source is deferred until the next frame boundary, so no frame is cut short. There is one exception. If the recovered clock is in use and the receiver reports loss of signal, the block stops sending, drives both rails low and raises a status flag. A new source picked in this state takes over at once.

Top module: `ds3tx_timing_sel`

## Requirements
- R1: `cfg_src_sel` decodes as follows: 2'b00 = recovered receive strobe `rx_bit_en`; 2'b01 = local strobe `txin_bit_en`; 2'b10 = frame-reference mode, with bits timed by `txin_bit_en`; 2'b11 behaves exactly as 2'b01.
- R2: Each strobe of the active source raises `bit_en` for exactly one cycle, in the cycle after the strobe. A strobe from a source that is not active causes no `bit_en`.
- R3: Bit positions run from 0 to FRAME_BITS-1 (default 4760) and then wrap to 0. `frame_start` is high together with `bit_en` only for bit 0.
- R4: `tx_pos` takes the value of `frame_bit` present in the strobe cycle. It holds that value until the next accepted bit.
- R5: `tx_neg` is 1 for the whole bit period of bit 0 and 0 for every other bit.
- R6: In frame-reference mode, a rising edge on `fref_in` passes a two-flop synchronizer and an edge detector. It then makes the next accepted bit bit 0, wherever the count stood. In the other modes, edges on `fref_in` have no effect on the count.
- R7: A new `cfg_src_sel` value is adopted only in a cycle with no strobe in which the next bit to send is bit 0. A change made mid-frame leaves the old source in use until the frame ends.
- R8: While the recovered strobe is active and `rx_los` is 1, `bit_en` stays low, both rails are driven low, and `timing_lost` is 1 one cycle later. In the other modes, `rx_los` is ignored.
- R9: While timing is lost, a newly selected source is adopted in the next cycle, and the bit position is kept.
- R10: After reset, all outputs are low, the next bit is bit 0, and the local strobe is the active source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src_sel | input | 2 | Timing source select |
| rx_bit_en | input | 1 | Bit strobe derived from the recovered receive clock |
| rx_los | input | 1 | Receiver loss-of-signal indication |
| txin_bit_en | input | 1 | Bit strobe derived from the local transmit clock |
| fref_in | input | 1 | Asynchronous frame-rate reference |
| frame_bit | input | 1 | Serial frame data for the bit being started |
| bit_en | output | 1 | One-cycle pulse per transmitted bit |
| frame_start | output | 1 | One-cycle pulse on bit 0 of each M-frame |
| tx_pos | output | 1 | Positive rail: serial frame data |
| tx_neg | output | 1 | Negative rail: frame-boundary marker |
| timing_lost | output | 1 | Active timing source has failed |

## Verification
A corrupted bit position shows up on the first strobe after the fault: `frame_start` and `tx_neg` appear on the wrong bit, or fail to appear at the 4760-bit wrap, and the bench's own position model catches it. A wrong active-source register shows up as soon as a strobe is taken or dropped against the selection. A restart request that is lost shows up on the first strobe after a reference edge. The bench walks full frames, switches source at and away from boundaries, and covers loss of signal with a switch while timing is lost.

// File: rtl/ds3tx_pkg.sv
package ds3tx_pkg;
   typedef enum logic [1:0] {
      SRC_RXCLK = 2'b00,
      SRC_TXCLK = 2'b01,
      SRC_FREF  = 2'b10
   } src_e;

   // Reserved code 2'b11 folds onto the local clock (R1)
   function automatic src_e decode_sel(input logic [1:0] sel);
      case (sel)
         2'b00:   return SRC_RXCLK;
         2'b10:   return SRC_FREF;
         default: return SRC_TXCLK;
      endcase
   endfunction
endpackage

// File: rtl/ds3tx_ref_edge.sv
module ds3tx_ref_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_async,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ds3tx_ref_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], ref_async};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~last_q;

   // R6: a detected edge lasts exactly one cycle
   assert_single_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);
endmodule

// File: rtl/ds3tx_src_ctrl.sv
module ds3tx_src_ctrl
   import ds3tx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cfg_sel,
   input  logic       at_boundary,
   input  logic       rx_bit_en,
   input  logic       rx_los,
   input  logic       tx_bit_en,
   output src_e       active_src,
   output logic       strobe,
   output logic       lost_now
);
   always_comb begin
      case (active_src)
         SRC_RXCLK: strobe = rx_bit_en & ~rx_los;
         default:   strobe = tx_bit_en;
      endcase
   end

   assign lost_now = (active_src == SRC_RXCLK) && rx_los;

   always_ff @(posedge clk) begin
      if (!rst_n) active_src <= SRC_TXCLK;
      else if (lost_now || (at_boundary && !strobe)) active_src <= decode_sel(cfg_sel);
   end

   // R7/R9: the source may only move at a frame boundary or while timing is lost
   assert_src_change_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(active_src) |-> $past(at_boundary || lost_now));
endmodule

// File: rtl/ds3tx_bit_ctr.sv
module ds3tx_bit_ctr #(
   parameter int FRAME_BITS = 4760,
   localparam int CW = $clog2(FRAME_BITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe,
   input  logic          restart_req,
   output logic [CW-1:0] eff_idx,
   output logic          at_boundary
);
   generate
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("ds3tx_bit_ctr: FRAME_BITS must be at least 2");
      end
   endgenerate

   localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

   logic [CW-1:0] cnt_q;
   logic          pending_q;

   assign eff_idx     = pending_q ? '0 : cnt_q;
   assign at_boundary = pending_q || (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         pending_q <= 1'b0;
      end else begin
         if (restart_req)  pending_q <= 1'b1;
         else if (strobe)  pending_q <= 1'b0;
         if (strobe) cnt_q <= (eff_idx == LAST_IDX) ? '0 : eff_idx + 1'b1;
      end
   end

   // R3: position never leaves the frame
   assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_IDX);
endmodule

// File: rtl/ds3tx_timing_sel.sv
module ds3tx_timing_sel
   import ds3tx_pkg::*;
#(
   parameter int FRAME_BITS  = 4760,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cfg_src_sel,
   input  logic       rx_bit_en,
   input  logic       rx_los,
   input  logic       txin_bit_en,
   input  logic       fref_in,
   input  logic       frame_bit,
   output logic       bit_en,
   output logic       frame_start,
   output logic       tx_pos,
   output logic       tx_neg,
   output logic       timing_lost
);
   localparam int CW = $clog2(FRAME_BITS);

   src_e          active_src;
   logic          strobe, lost_now, ref_rise, at_boundary;
   logic [CW-1:0] eff_idx;
   logic          first_bit;

   ds3tx_ref_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .ref_async(fref_in), .rise(ref_rise));

   ds3tx_src_ctrl u_src (
      .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_src_sel), .at_boundary(at_boundary),
      .rx_bit_en(rx_bit_en), .rx_los(rx_los), .tx_bit_en(txin_bit_en),
      .active_src(active_src), .strobe(strobe), .lost_now(lost_now));

   ds3tx_bit_ctr #(.FRAME_BITS(FRAME_BITS)) u_ctr (
      .clk(clk), .rst_n(rst_n), .strobe(strobe),
      .restart_req(ref_rise && (active_src == SRC_FREF)),
      .eff_idx(eff_idx), .at_boundary(at_boundary));

   assign first_bit = (eff_idx == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_en      <= 1'b0;
         frame_start <= 1'b0;
         tx_pos      <= 1'b0;
         tx_neg      <= 1'b0;
         timing_lost <= 1'b0;
      end else begin
         bit_en      <= strobe;
         frame_start <= strobe && first_bit;
         timing_lost <= lost_now;
         if (lost_now) begin
            tx_pos <= 1'b0;
            tx_neg <= 1'b0;
         end else if (strobe) begin
            tx_pos <= frame_bit;
            tx_neg <= first_bit;
         end
      end
   end

   assert_start_has_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> bit_en);
   assert_neg_marks_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en |-> (tx_neg == frame_start));
   assert_lost_rails_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timing_lost |-> (!tx_pos && !tx_neg && !bit_en));
endmodule

// File: tb/sim_ds3tx_timing_sel.sv
`timescale 1ns/1ps
module sim_ds3tx_timing_sel;
   localparam int FB = 4760;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_src_sel = 2'b01;
   logic       rx_bit_en = 1'b0, rx_los = 1'b0, txin_bit_en = 1'b0;
   logic       fref_in = 1'b0, frame_bit = 1'b0;
   logic       bit_en, frame_start, tx_pos, tx_neg, timing_lost;

   int n_chk = 0, n_fail = 0;
   int exp_idx = 0;

   always #2 clk = ~clk;

   ds3tx_timing_sel u0 (
      .clk(clk), .rst_n(rst_n), .cfg_src_sel(cfg_src_sel), .rx_bit_en(rx_bit_en),
      .rx_los(rx_los), .txin_bit_en(txin_bit_en), .fref_in(fref_in),
      .frame_bit(frame_bit), .bit_en(bit_en), .frame_start(frame_start),
      .tx_pos(tx_pos), .tx_neg(tx_neg), .timing_lost(timing_lost));

   // Table entries: [4:3] select, [2] strobe on rx side, [1] rx_los, [0] bit expected
   localparam logic [4:0] VEC [10] = '{
      5'b00_1_0_1, 5'b00_0_0_0, 5'b00_1_1_0, 5'b01_0_0_1, 5'b01_1_0_0,
      5'b10_0_0_1, 5'b10_1_0_0, 5'b11_0_0_1, 5'b11_1_0_0, 5'b01_0_1_1};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic do_reset(input logic [1:0] sel);
      rst_n = 1'b0;
      cfg_src_sel = sel;
      tick(3);
      rst_n = 1'b1;
      exp_idx = 0;
   endtask

   // One strobe; check the outputs one cycle later against the bench model
   task automatic send(input bit use_rx, input bit d, input bit taken);
      rx_bit_en = use_rx;
      txin_bit_en = !use_rx;
      frame_bit = d;
      tick(1);
      rx_bit_en = 1'b0;
      txin_bit_en = 1'b0;
      chk(bit_en == taken, "R2 bit_en", bit_en, taken);
      if (taken) begin
         chk(frame_start == (exp_idx == 0), "R3 frame_start", frame_start, exp_idx == 0);
         chk(tx_pos == d, "R4 tx_pos", tx_pos, d);
         chk(tx_neg == (exp_idx == 0), "R5 tx_neg", tx_neg, exp_idx == 0);
         exp_idx = (exp_idx == FB - 1) ? 0 : exp_idx + 1;
      end
   endtask

   task automatic send_to_wrap();
      while (exp_idx != 0) send(1'b0, exp_idx[0] ^ exp_idx[3], 1'b1);
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R10 reset state
      tick(2);
      chk({bit_en, frame_start, tx_pos, tx_neg, timing_lost} == 5'b0, "R10 reset outputs",
          {bit_en, frame_start, tx_pos, tx_neg, timing_lost}, 0);

      // Table walk: R1 decoding, R2 gating, R8 loss flag
      foreach (VEC[k]) begin
         do_reset(VEC[k][4:3]);
         rx_los = VEC[k][1];
         tick(2);
         chk(timing_lost == (VEC[k][4:3] == 2'b00 && VEC[k][1]), "R8 timing_lost",
             timing_lost, VEC[k][4:3] == 2'b00 && VEC[k][1]);
         send(VEC[k][2], 1'b1, VEC[k][0]);
         chk(frame_start == VEC[k][0], "R1 first bit of source", frame_start, VEC[k][0]);
         rx_los = 1'b0;
      end

      // R10 local source after reset; R3/R4/R5 over a full frame plus wrap
      do_reset(2'b01);
      tick(1);
      send(1'b1, 1'b1, 1'b0);
      for (int i = 0; i < FB + 2; i++) begin
         send(1'b0, i[0] ^ i[3], 1'b1);
         if (i == 0) begin
            tick(3);
            chk(tx_neg == 1'b1, "R5 tx_neg held in bit 0", tx_neg, 1);
         end
      end
      // R6 reference edge ignored outside reference mode
      fref_in = 1'b1;
      tick(5);
      send(1'b0, 1'b0, 1'b1);
      fref_in = 1'b0;

      // R7 mid-frame select change is deferred
      cfg_src_sel = 2'b00;
      tick(2);
      send(1'b1, 1'b1, 1'b0);
      send(1'b0, 1'b1, 1'b1);
      send_to_wrap();
      tick(2);
      send(1'b0, 1'b1, 1'b0);
      send(1'b1, 1'b1, 1'b1);
      chk(exp_idx == 1, "R7 new source starts at bit 0", exp_idx, 1);

      // R8 loss of signal on the recovered source
      rx_los = 1'b1;
      tick(2);
      chk(timing_lost == 1'b1, "R8 timing_lost", timing_lost, 1);
      chk(tx_pos == 1'b0 && tx_neg == 1'b0, "R8 rails low", {tx_pos, tx_neg}, 0);
      send(1'b1, 1'b1, 1'b0);
      // R9 immediate switch while lost, position kept
      cfg_src_sel = 2'b01;
      tick(2);
      chk(timing_lost == 1'b0, "R9 flag clears after switch", timing_lost, 0);
      send(1'b0, 1'b1, 1'b1);
      chk(exp_idx == 2, "R9 position kept", exp_idx, 2);
      rx_los = 1'b0;

      // R6 reference mode: edge restarts the frame mid-way
      cfg_src_sel = 2'b10;
      send_to_wrap();
      tick(2);
      for (int i = 0; i < 20; i++) send(1'b0, i[1], 1'b1);
      fref_in = 1'b1;
      tick(5);
      exp_idx = 0;
      send(1'b0, 1'b1, 1'b1);
      chk(frame_start == 1'b1, "R6 restart at bit 0", frame_start, 1);
      fref_in = 1'b0;
      for (int i = 0; i < 5; i++) send(1'b0, i[0], 1'b1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule